// File: doc/BRIEF.md
# SPI Channel Transfer Sequencer

This block is the per-channel decision logic of a serial peripheral interface controller. It watches the channel's configuration, its enable, and the strobes that mark a write of transmit data or a read of receive data. From these it decides when the next word may be exchanged, and it issues a one-cycle start to an external shift engine. It keeps the channel's three status flags (transmit empty, receive full, end of transfer). From those flags it derives one-cycle interrupt events and level DMA requests for each direction.

The channel runs in one of three directions: full duplex, receive only or transmit only. A turbo setting lets a full-duplex or receive-only channel start another word while the previous received word is still unread. A module-level single-channel setting, together with a per-channel force bit, decides whether the word is actually driven onto the bus or only sequenced. The shift engine reports completion with a done pulse, and all status updates happen on that cycle. Bit-level shifting and serial clock division belong to the engine and are not part of this block.

The reset input is asserted asynchronously and released through a two-stage synchronizer. Internal state therefore leaves reset two clock edges after `rst_n` rises.

Top module: `spi_xfer_seq`

## Requirements
- R1: After reset the status reads transmit empty = 1, receive full = 0, end of transfer = 0, with no start, no events and no DMA request while the enable is low.
- R2: `cfg_mode` encodes 0 = full duplex, 1 = receive only, 2 = transmit only. Value 3 raises `cfg_mode_bad` and is otherwise sequenced like full duplex. `word_len` equals `cfg_wlen` + 1, and `cfg_wlen_bad` is high when `cfg_wlen` is below 3.
- R3: A `tx_wr` strobe clears transmit empty and end of transfer. An `rx_rd` strobe clears receive full. Each of these strobes, and a rising edge of `ch_en`, requests a transfer attempt. The attempt is evaluated on the clock edge after the strobe's edge, so a granted start is visible one cycle after the strobe has been taken.
- R4: An attempt yields no start if any of these holds: `ch_en` is low; receive full is set while the mode is not transmit only and turbo is off; transmit empty is set while the mode is not receive only. A blocked attempt is dropped.
- R5: `eng_start` is high for exactly one cycle. No further start is issued until `eng_done` has been seen. An attempt requested while a word is in flight is held and evaluated once the engine has finished.
- R6: `eng_drive` is captured with each start and equals (not `single_mode`) or `cfg_force`.
- R7: On the edge that takes `eng_done` while a word is in flight, transmit empty and end of transfer set. Receive full sets unless the mode is transmit only, in which case it keeps its value.
- R8: `dma_tx_req` = `ch_en` and `cfg_dma_tx` and transmit empty and mode not receive only.
- R9: `dma_rx_req` = `ch_en` and `cfg_dma_rx` and receive full and mode not transmit only.
- R10: `ev_tx_empty` pulses for one cycle when (transmit empty and mode not receive only) becomes true. `ev_rx_full` pulses for one cycle when (receive full and mode not transmit only and turbo off) becomes true.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode | input | 2 | Direction select (0 duplex, 1 receive only, 2 transmit only) |
| cfg_wlen | input | WLEN_W | Word length minus one |
| cfg_turbo | input | 1 | Allow a start while received data is unread |
| cfg_force | input | 1 | Drive the word even in single-channel mode |
| cfg_dma_tx | input | 1 | Enable transmit DMA request |
| cfg_dma_rx | input | 1 | Enable receive DMA request |
| ch_en | input | 1 | Channel enable level |
| single_mode | input | 1 | Module-level single-channel setting |
| tx_wr | input | 1 | Transmit data written strobe |
| rx_rd | input | 1 | Receive data read strobe |
| eng_done | input | 1 | Shift engine finished the word |
| eng_start | output | 1 | One-cycle start to the shift engine |
| eng_drive | output | 1 | The started word is driven onto the bus |
| word_len | output | WLEN_W+1 | Bits per word |
| cfg_mode_bad | output | 1 | Direction field holds the unused code |
| cfg_wlen_bad | output | 1 | Word length field below the legal minimum |
| st_rx_full | output | 1 | Receive full flag |
| st_tx_empty | output | 1 | Transmit empty flag |
| st_eot | output | 1 | End of transfer flag |
| ev_tx_empty | output | 1 | Transmit-empty interrupt event |
| ev_rx_full | output | 1 | Receive-full interrupt event |
| dma_tx_req | output | 1 | Transmit DMA request level |
| dma_rx_req | output | 1 | Receive DMA request level |

## Verification
The hardest case to reach is an attempt that arrives while a word is still in the shift engine and that must survive until the engine finishes. It only yields a start when the flags that done sets do not block it, which means receive-only mode with turbo on. The bench puts the channel in that configuration, starts a word, strobes a receive read while the engine is busy, and then expects a start on the second edge after done. The other blocking rules are reached by sweeping every direction against every combination of turbo, single, force and the two DMA enables. In the full-duplex sweeps the bench starts a second word without reading the first, which shows turbo tolerating unread data.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;

  typedef enum logic [1:0] {
    MODE_DUPLEX  = 2'd0,
    MODE_RX_ONLY = 2'd1,
    MODE_TX_ONLY = 2'd2,
    MODE_UNUSED  = 2'd3
  } xfer_mode_e;

  // receive side takes part in the exchange
  function automatic logic rx_active(xfer_mode_e m);
    return m != MODE_TX_ONLY;
  endfunction

  // transmit side takes part in the exchange
  function automatic logic tx_active(xfer_mode_e m);
    return m != MODE_RX_ONLY;
  endfunction

endpackage

// File: rtl/spi_seq_trig.sv
module spi_seq_trig (
  input  logic clk,
  input  logic rst_ni,
  input  logic ch_en,
  input  logic tx_wr,
  input  logic rx_rd,
  input  logic consume,
  output logic pend
);
  logic en_prev_q, en_prev_d;
  logic pend_q, pend_d;
  logic trig;

  always_comb begin
    trig      = tx_wr | rx_rd | (ch_en & ~en_prev_q);
    en_prev_d = ch_en;
    pend_d    = trig | (pend_q & ~consume);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      en_prev_q <= 1'b0;
      pend_q    <= 1'b0;
    end else begin
      en_prev_q <= en_prev_d;
      pend_q    <= pend_d;
    end
  end

  assign pend = pend_q;

  // R3: every trigger leaves an attempt request behind
  a_r3_trigger_pends: assert property (@(posedge clk) disable iff (!rst_ni)
    (tx_wr || rx_rd) |=> pend_q);

endmodule

// File: rtl/spi_seq_flags.sv
module spi_seq_flags
  import spi_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_ni,
  input  xfer_mode_e mode,
  input  logic       tx_wr,
  input  logic       rx_rd,
  input  logic       done_acc,
  output logic       tx_empty,
  output logic       rx_full,
  output logic       eot
);
  logic tx_empty_q, tx_empty_d;
  logic rx_full_q, rx_full_d;
  logic eot_q, eot_d;

  always_comb begin
    tx_empty_d = tx_empty_q;
    rx_full_d  = rx_full_q;
    eot_d      = eot_q;
    if (done_acc) begin
      tx_empty_d = 1'b1;
      eot_d      = 1'b1;
      rx_full_d  = rx_full_q | rx_active(mode);
    end else begin
      if (tx_wr) begin
        tx_empty_d = 1'b0;
        eot_d      = 1'b0;
      end
      if (rx_rd) rx_full_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_empty_q <= 1'b1;
      rx_full_q  <= 1'b0;
      eot_q      <= 1'b0;
    end else begin
      tx_empty_q <= tx_empty_d;
      rx_full_q  <= rx_full_d;
      eot_q      <= eot_d;
    end
  end

  assign tx_empty = tx_empty_q;
  assign rx_full  = rx_full_q;
  assign eot      = eot_q;

  // R7: completion sets transmit empty and end of transfer
  a_r7_done_sets: assert property (@(posedge clk) disable iff (!rst_ni)
    done_acc |=> (tx_empty_q && eot_q));
  // R7: transmit-only completion never raises receive full
  a_r7_txonly_rx: assert property (@(posedge clk) disable iff (!rst_ni)
    (done_acc && mode == MODE_TX_ONLY && !rx_full_q) |=> !rx_full_q);
  // R3: a write with no completion clears transmit empty
  a_r3_write_clears: assert property (@(posedge clk) disable iff (!rst_ni)
    (tx_wr && !done_acc) |=> !tx_empty_q);
  // R3: a read with no completion clears receive full
  a_r3_read_clears: assert property (@(posedge clk) disable iff (!rst_ni)
    (rx_rd && !done_acc) |=> !rx_full_q);

endmodule

// File: rtl/spi_seq_ctrl.sv
module spi_seq_ctrl
  import spi_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_ni,
  input  xfer_mode_e mode,
  input  logic       ch_en,
  input  logic       turbo,
  input  logic       single_mode,
  input  logic       force_cs,
  input  logic       pend,
  input  logic       tx_empty,
  input  logic       rx_full,
  input  logic       eng_done,
  output logic       consume,
  output logic       done_acc,
  output logic       start,
  output logic       drive
);
  logic busy_q, busy_d;
  logic start_q, start_d;
  logic drive_q, drive_d;
  logic rx_block, tx_block, go;

  always_comb begin
    rx_block = rx_full & rx_active(mode) & ~turbo;
    tx_block = tx_empty & tx_active(mode);
    consume  = pend & ~busy_q;
    go       = consume & ch_en & ~rx_block & ~tx_block;
    done_acc = eng_done & busy_q;
    start_d  = go;
    drive_d  = go ? (~single_mode | force_cs) : drive_q;
    if (go)
      busy_d = 1'b1;
    else if (done_acc)
      busy_d = 1'b0;
    else
      busy_d = busy_q;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      start_q <= 1'b0;
      drive_q <= 1'b0;
    end else begin
      busy_q  <= busy_d;
      start_q <= start_d;
      drive_q <= drive_d;
    end
  end

  assign start = start_q;
  assign drive = drive_q;

  // R5: start lasts one cycle
  a_r5_start_pulse: assert property (@(posedge clk) disable iff (!rst_ni)
    start_q |=> !start_q);
  // R5: no start while a word is in flight
  a_r5_no_restart: assert property (@(posedge clk) disable iff (!rst_ni)
    (busy_q && !eng_done) |=> !start_q);
  // R4: nothing starts while the channel is disabled
  a_r4_enable_gate: assert property (@(posedge clk) disable iff (!rst_ni)
    !ch_en |=> !start_q);

endmodule

// File: rtl/spi_seq_irq.sv
module spi_seq_irq
  import spi_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_ni,
  input  xfer_mode_e mode,
  input  logic       ch_en,
  input  logic       turbo,
  input  logic       dma_tx_en,
  input  logic       dma_rx_en,
  input  logic       tx_empty,
  input  logic       rx_full,
  output logic       ev_tx,
  output logic       ev_rx,
  output logic       dreq_tx,
  output logic       dreq_rx
);
  logic tx_cond, rx_cond;
  logic tx_prev_q, tx_prev_d;
  logic rx_prev_q, rx_prev_d;

  always_comb begin
    tx_cond   = tx_empty & tx_active(mode);
    rx_cond   = rx_full & rx_active(mode) & ~turbo;
    tx_prev_d = tx_cond;
    rx_prev_d = rx_cond;
    ev_tx     = tx_cond & ~tx_prev_q;
    ev_rx     = rx_cond & ~rx_prev_q;
    dreq_tx   = ch_en & dma_tx_en & tx_empty & tx_active(mode);
    dreq_rx   = ch_en & dma_rx_en & rx_full & rx_active(mode);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_prev_q <= 1'b1;
      rx_prev_q <= 1'b0;
    end else begin
      tx_prev_q <= tx_prev_d;
      rx_prev_q <= rx_prev_d;
    end
  end

  // R10: events are single-cycle pulses
  a_r10_tx_pulse: assert property (@(posedge clk) disable iff (!rst_ni)
    ev_tx |=> !ev_tx);
  a_r10_rx_pulse: assert property (@(posedge clk) disable iff (!rst_ni)
    ev_rx |=> !ev_rx);
  // R8: transmit request only with transmit empty
  a_r8_dma_tx: assert property (@(posedge clk) disable iff (!rst_ni)
    dreq_tx |-> (tx_empty && ch_en));
  // R9: receive request only with receive full
  a_r9_dma_rx: assert property (@(posedge clk) disable iff (!rst_ni)
    dreq_rx |-> (rx_full && ch_en));

endmodule

// File: rtl/spi_xfer_seq.sv
module spi_xfer_seq
  import spi_seq_pkg::*;
#(
  parameter int WLEN_W   = 5,
  parameter int WLEN_MIN = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cfg_mode,
  input  logic [WLEN_W-1:0] cfg_wlen,
  input  logic              cfg_turbo,
  input  logic              cfg_force,
  input  logic              cfg_dma_tx,
  input  logic              cfg_dma_rx,
  input  logic              ch_en,
  input  logic              single_mode,
  input  logic              tx_wr,
  input  logic              rx_rd,
  input  logic              eng_done,
  output logic              eng_start,
  output logic              eng_drive,
  output logic [WLEN_W:0]   word_len,
  output logic              cfg_mode_bad,
  output logic              cfg_wlen_bad,
  output logic              st_rx_full,
  output logic              st_tx_empty,
  output logic              st_eot,
  output logic              ev_tx_empty,
  output logic              ev_rx_full,
  output logic              dma_tx_req,
  output logic              dma_rx_req
);
  localparam int LEN_W = WLEN_W + 1;

  logic       rst_s1_q, rst_s2_q;
  logic       rst_ni;
  xfer_mode_e mode;
  logic       pend, consume, done_acc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end
  assign rst_ni = rst_s2_q;

  assign mode         = xfer_mode_e'(cfg_mode);
  assign word_len     = LEN_W'(cfg_wlen) + LEN_W'(1);
  assign cfg_mode_bad = (mode == MODE_UNUSED);
  assign cfg_wlen_bad = (int'(cfg_wlen) < WLEN_MIN);

  spi_seq_trig u_trig (
    .clk     (clk),
    .rst_ni  (rst_ni),
    .ch_en   (ch_en),
    .tx_wr   (tx_wr),
    .rx_rd   (rx_rd),
    .consume (consume),
    .pend    (pend)
  );

  spi_seq_ctrl u_ctrl (
    .clk         (clk),
    .rst_ni      (rst_ni),
    .mode        (mode),
    .ch_en       (ch_en),
    .turbo       (cfg_turbo),
    .single_mode (single_mode),
    .force_cs    (cfg_force),
    .pend        (pend),
    .tx_empty    (st_tx_empty),
    .rx_full     (st_rx_full),
    .eng_done    (eng_done),
    .consume     (consume),
    .done_acc    (done_acc),
    .start       (eng_start),
    .drive       (eng_drive)
  );

  spi_seq_flags u_flags (
    .clk      (clk),
    .rst_ni   (rst_ni),
    .mode     (mode),
    .tx_wr    (tx_wr),
    .rx_rd    (rx_rd),
    .done_acc (done_acc),
    .tx_empty (st_tx_empty),
    .rx_full  (st_rx_full),
    .eot      (st_eot)
  );

  spi_seq_irq u_irq (
    .clk       (clk),
    .rst_ni    (rst_ni),
    .mode      (mode),
    .ch_en     (ch_en),
    .turbo     (cfg_turbo),
    .dma_tx_en (cfg_dma_tx),
    .dma_rx_en (cfg_dma_rx),
    .tx_empty  (st_tx_empty),
    .rx_full   (st_rx_full),
    .ev_tx     (ev_tx_empty),
    .ev_rx     (ev_rx_full),
    .dreq_tx   (dma_tx_req),
    .dreq_rx   (dma_rx_req)
  );

  // R6: the drive qualifier follows the single/force setting at start
  a_r6_drive: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(eng_start) |-> (eng_drive == ($past(~single_mode) | $past(cfg_force))));
  // R2: bits per word is never zero
  a_r2_len_nonzero: assert property (@(posedge clk) disable iff (!rst_ni)
    word_len != '0);

endmodule

// File: tb/test_spi_xfer_seq.sv
module test_spi_xfer_seq;
  logic       clk;
  logic       rst_n;
  logic [1:0] cfg_mode;
  logic [4:0] cfg_wlen;
  logic       cfg_turbo, cfg_force, cfg_dma_tx, cfg_dma_rx;
  logic       ch_en, single_mode, tx_wr, rx_rd, eng_done;
  logic       eng_start, eng_drive, cfg_mode_bad, cfg_wlen_bad;
  logic [5:0] word_len;
  logic       st_rx_full, st_tx_empty, st_eot;
  logic       ev_tx_empty, ev_rx_full, dma_tx_req, dma_rx_req;

  int total = 0;
  int bad   = 0;
  bit finished = 0;

  spi_xfer_seq i_spi_xfer_seq (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_wlen(cfg_wlen),
    .cfg_turbo(cfg_turbo), .cfg_force(cfg_force), .cfg_dma_tx(cfg_dma_tx),
    .cfg_dma_rx(cfg_dma_rx), .ch_en(ch_en), .single_mode(single_mode),
    .tx_wr(tx_wr), .rx_rd(rx_rd), .eng_done(eng_done),
    .eng_start(eng_start), .eng_drive(eng_drive), .word_len(word_len),
    .cfg_mode_bad(cfg_mode_bad), .cfg_wlen_bad(cfg_wlen_bad),
    .st_rx_full(st_rx_full), .st_tx_empty(st_tx_empty), .st_eot(st_eot),
    .ev_tx_empty(ev_tx_empty), .ev_rx_full(ev_rx_full),
    .dma_tx_req(dma_tx_req), .dma_rx_req(dma_rx_req)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic do_reset();
    ch_en = 0; tx_wr = 0; rx_rd = 0; eng_done = 0;
    rst_n = 0;
    tick(); tick();
    rst_n = 1;
    tick(); tick(); tick();
  endtask

  task automatic pulse_tx();
    tx_wr = 1; tick(); tx_wr = 0;
  endtask

  task automatic pulse_rx();
    rx_rd = 1; tick(); rx_rd = 0;
  endtask

  task automatic pulse_done();
    eng_done = 1; tick(); eng_done = 0;
  endtask

  task automatic chk_done(int m, bit tb, bit dtx, bit drx);
    int ru = (m != 2);
    int tu = (m != 1);
    chk("R7 tx_empty after done", st_tx_empty, 1);
    chk("R7 eot after done", st_eot, 1);
    chk("R7 rx_full after done", st_rx_full, ru);
    chk("R10 tx event", ev_tx_empty, tu);
    chk("R10 rx event", ev_rx_full, ru & int'(!tb));
    chk("R8 dma tx", dma_tx_req, int'(dtx) & tu);
    chk("R9 dma rx", dma_rx_req, int'(drx) & ru);
    tick();
    chk("R10 tx event one cycle", ev_tx_empty, 0);
    chk("R10 rx event one cycle", ev_rx_full, 0);
  endtask

  initial begin
    rst_n = 0; ch_en = 0; tx_wr = 0; rx_rd = 0; eng_done = 0;
    cfg_mode = 0; cfg_wlen = 7; cfg_turbo = 0; cfg_force = 0;
    cfg_dma_tx = 0; cfg_dma_rx = 0; single_mode = 0;

    // R2: field decoding
    for (int w = 0; w < 32; w++) begin
      cfg_wlen = 5'(w);
      #1;
      chk("R2 word_len", int'(word_len), w + 1);
      chk("R2 wlen_bad", cfg_wlen_bad, int'(w < 3));
    end
    for (int m = 0; m < 4; m++) begin
      cfg_mode = 2'(m);
      #1;
      chk("R2 mode_bad", cfg_mode_bad, int'(m == 3));
    end
    cfg_wlen = 7;

    // sweep directions against turbo/single/force/dma enables
    for (int m = 0; m < 3; m++) begin
      for (int cb = 0; cb < 32; cb++) begin
        bit tb = cb[0];
        bit sg = cb[1];
        bit fc = cb[2];
        bit dt = cb[3];
        bit dr = cb[4];
        int tu = (m != 1);
        cfg_mode = 2'(m); cfg_turbo = tb; single_mode = sg; cfg_force = fc;
        cfg_dma_tx = dt; cfg_dma_rx = dr;
        do_reset();
        chk("R1 reset tx_empty", st_tx_empty, 1);
        chk("R1 reset rx_full", st_rx_full, 0);
        chk("R1 reset eot", st_eot, 0);
        chk("R1 reset start", eng_start, 0);
        chk("R1 reset events", int'(ev_tx_empty | ev_rx_full), 0);
        chk("R1 reset dma", int'(dma_tx_req | dma_rx_req), 0);
        // enable rising edge is a trigger
        ch_en = 1;
        tick(); tick();
        chk("R4 start on enable rise", eng_start, int'(m == 1));
        chk("R8 dma tx idle", dma_tx_req, int'(dt) & tu);
        if (m != 1) begin
          pulse_tx();
          chk("R3 write clears tx_empty", st_tx_empty, 0);
          chk("R3 no start on strobe edge", eng_start, 0);
          tick();
          chk("R3 start after write", eng_start, 1);
        end
        chk("R6 drive", eng_drive, int'(!sg || fc));
        chk("R2 word_len held", int'(word_len), 8);
        tick();
        chk("R5 start one cycle", eng_start, 0);
        tick(); tick();
        chk("R5 no start while busy", eng_start, 0);
        pulse_done();
        chk_done(m, tb, dt, dr);
        // second word
        if (m == 0) begin
          pulse_tx();
          chk("R3 write clears eot", st_eot, 0);
          tick();
          chk("R4 turbo vs unread rx", eng_start, int'(tb));
          if (!tb) begin
            pulse_rx();
            chk("R3 read clears rx_full", st_rx_full, 0);
            tick();
            chk("R4 start after read", eng_start, 1);
          end
        end else if (m == 1) begin
          pulse_rx();
          chk("R3 read clears rx_full", st_rx_full, 0);
          tick();
          chk("R4 rx-only start after read", eng_start, 1);
        end else begin
          pulse_tx();
          tick();
          chk("R4 tx-only ignores rx_full", eng_start, 1);
        end
        tick();
        pulse_done();
        chk_done(m, tb, dt, dr);
      end
    end

    // R4: disabled channel drops the attempt, enable rise retries
    cfg_mode = 2; cfg_turbo = 0; single_mode = 0; cfg_force = 0;
    do_reset();
    pulse_tx();
    tick();
    chk("R4 disabled no start", eng_start, 0);
    tick();
    chk("R4 disabled still no start", eng_start, 0);
    ch_en = 1;
    tick(); tick();
    chk("R3 enable rise starts", eng_start, 1);
    tick();
    pulse_done();

    // R5: attempt requested while busy is held until done
    cfg_mode = 1; cfg_turbo = 1;
    do_reset();
    ch_en = 1;
    tick(); tick();
    chk("R5 rx-only first start", eng_start, 1);
    tick();
    pulse_rx();
    tick(); tick();
    chk("R5 held attempt waits", eng_start, 0);
    pulse_done();
    chk("R5 no start on done edge", eng_start, 0);
    tick();
    chk("R5 held attempt starts", eng_start, 1);
    tick();
    chk("R5 held start one cycle", eng_start, 0);
    pulse_done();

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule